// File: doc/BRIEF.md
# Parse-Tree Reduction Record Packer

This block sits beside a bottom-up parser and turns each reduction into one record of a serialized parse tree. When the parser reduces, it supplies the nonterminal symbol it creates and the number of children. It then hands over the children one by one. A child is either a terminal token number or the index of a record emitted earlier. The block gives every record a sequential index and presents the index of the next record while it is idle. The parser keeps that index on its side stack, so later records can refer to the nonterminal it creates.

Records are packed as one continuous bit stream into fixed-width memory words. A record may span word boundaries, and the block never reads back what it has written, so the stream can be forwarded as it is produced. A flush writes out the last partial word. If a word would land beyond the last memory address, the block stops in a fault state until reset.

Top module: `parse_record_packer`

## Requirements
- R1: After reset, ready_o is 1, fault_o is 0, rec_idx_o is 0 and no memory write occurs.
- R2: A record starts with a header: the symbol (SYM_W bits) then the child count (CNT_W bits). Every field enters the stream least significant bit first, and stream bit k is bit k%WORD_W of word k/WORD_W.
- R3: The header is followed by one slot per child. A slot is a tag bit followed by an ID_W-bit identifier. Tag 0 means the identifier is a terminal token number. Tag 1 means it is the index of an earlier record.
- R4: Record indices start at 0 and rise by one per completed record. rec_idx_o shows the next index while ready_o is 1 and reads 0 otherwise.
- R5: Records are concatenated without padding. Full words are written to consecutive addresses starting at 0, one clock after the edge that accepted the field that filled the word.
- R6: A start pulse with a nonzero count drops ready_o until that many children have been accepted. Cycles with child_valid_i low add nothing, and a start while busy is ignored.
- R7: A record with zero children is complete at its start pulse, and ready_o stays 1.
- R8: A flush while idle writes a pending partial word with zeros above the valid bits, and writes nothing when no bits are pending. The next record begins at bit 0 of the following address.
- R9: A word write that would go past address DEPTH-1 is suppressed. fault_o then rises and ready_o falls, and both stay that way with all inputs ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a record; latches the symbol and the count |
| sym_i | input | SYM_W | Nonterminal symbol created by the reduction |
| count_i | input | CNT_W | Number of children of the record |
| child_valid_i | input | 1 | Child strobe, one child per cycle |
| child_tag_i | input | 1 | 0 = terminal, 1 = record index |
| child_id_i | input | ID_W | Token number or record index |
| flush_i | input | 1 | Writes out the pending partial word (honoured while idle) |
| ready_o | output | 1 | Idle and able to accept a start |
| fault_o | output | 1 | Memory overflow; sticky |
| rec_idx_o | output | ID_W | Index the next record will receive |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | WORD_W | Memory word data |

## Verification
ready_o, fault_o and rec_idx_o follow the state register, so they are valid in the cycle after the accepting edge. A memory word leaves through an output register and appears one clock after the edge that consumed its last field. The bench drives and samples on the falling edge. It captures every write at the falling edge that follows its strobe, and it waits at least one extra cycle after the last field or flush before it counts writes or compares words. Stream contents are checked twice: word by word against a bit stream built in the bench from the stimulus table, and by unpacking the captured words back into symbols, counts, tags and identifiers.

// File: rtl/rp_pkg.sv
package rp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_KIDS  = 2'd1,
    ST_FAULT = 2'd2
  } rp_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rp_ctrl.sv
module rp_ctrl
  import rp_pkg::*;
#(
  parameter int SYM_W = 3,
  parameter int CNT_W = 3,
  parameter int ID_W  = 5,
  parameter int FLD_W = 6,
  parameter int LEN_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [SYM_W-1:0] sym_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             child_valid_i,
  input  logic             child_tag_i,
  input  logic [ID_W-1:0]  child_id_i,
  input  logic             flush_i,
  input  logic             ovf_i,
  output logic             push_o,
  output logic [FLD_W-1:0] fval_o,
  output logic [LEN_W-1:0] flen_o,
  output logic             flush_o,
  output logic             ready_o,
  output logic             fault_o,
  output logic [ID_W-1:0]  rec_idx_o
);
  localparam int HDR_W  = SYM_W + CNT_W;
  localparam int SLOT_W = ID_W + 1;

  rp_state_e        state_q, state_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic [ID_W-1:0]  rec_q, rec_d;

  always_comb begin
    state_d = state_q;
    left_d  = left_q;
    rec_d   = rec_q;
    push_o  = 1'b0;
    fval_o  = '0;
    flen_o  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          push_o = 1'b1;
          fval_o = FLD_W'({count_i, sym_i});
          flen_o = LEN_W'(HDR_W);
          if (count_i == '0) begin
            rec_d = rec_q + 1'b1;
          end else begin
            state_d = ST_KIDS;
            left_d  = count_i;
          end
        end
      end
      ST_KIDS: begin
        if (child_valid_i) begin
          push_o = 1'b1;
          fval_o = FLD_W'({child_id_i, child_tag_i});  // tag enters stream first
          flen_o = LEN_W'(SLOT_W);
          left_d = left_q - 1'b1;
          if (left_q == CNT_W'(1)) begin
            state_d = ST_IDLE;
            rec_d   = rec_q + 1'b1;
          end
        end
      end
      default: ;
    endcase
    if (ovf_i) state_d = ST_FAULT;
  end

  assign flush_o   = flush_i && (state_q == ST_IDLE) && !start_i;
  assign ready_o   = (state_q == ST_IDLE);
  assign fault_o   = (state_q == ST_FAULT);
  assign rec_idx_o = ready_o ? rec_q : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      rec_q   <= '0;
    end else begin
      state_q <= state_d;
      left_q  <= left_d;
      rec_q   <= rec_d;
    end
  end
endmodule

// File: rtl/rp_accum.sv
module rp_accum #(
  parameter int WORD_W = 8,
  parameter int FLD_W  = 6,
  parameter int LEN_W  = 3,
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [FLD_W-1:0]  fval_i,
  input  logic [LEN_W-1:0]  flen_i,
  input  logic              flush_i,
  output logic              ovf_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [WORD_W-1:0] wdata_o
);
  localparam int ACC_W  = WORD_W + FLD_W;
  localparam int FILL_W = $clog2(ACC_W + 1);

  logic [ACC_W-1:0]  acc_q, acc_d, merged;
  logic [FILL_W-1:0] fill_q, fill_d, sum;
  logic [ADDR_W:0]   waddr_q;
  logic [WORD_W-1:0] wdata_d;
  logic              need_wr;

  assign merged = acc_q | (ACC_W'(fval_i) << fill_q);
  assign sum    = fill_q + FILL_W'(flen_i);

  always_comb begin
    need_wr = 1'b0;
    wdata_d = acc_q[WORD_W-1:0];
    acc_d   = acc_q;
    fill_d  = fill_q;
    if (push_i) begin
      if (sum >= FILL_W'(WORD_W)) begin
        need_wr = 1'b1;
        wdata_d = merged[WORD_W-1:0];
        acc_d   = merged >> WORD_W;
        fill_d  = sum - FILL_W'(WORD_W);
      end else begin
        acc_d  = merged;
        fill_d = sum;
      end
    end else if (flush_i && fill_q != '0) begin
      need_wr = 1'b1;  // upper bits of acc_q are already zero
      acc_d   = '0;
      fill_d  = '0;
    end
  end

  assign ovf_o = need_wr && (waddr_q == (ADDR_W+1)'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      fill_q  <= '0;
      waddr_q <= '0;
      we_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else begin
      we_o <= need_wr && !ovf_o;
      if (!ovf_o) begin
        acc_q  <= acc_d;
        fill_q <= fill_d;
      end
      if (need_wr && !ovf_o) begin
        addr_o  <= waddr_q[ADDR_W-1:0];
        wdata_o <= wdata_d;
        waddr_q <= waddr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/parse_record_packer.sv
module parse_record_packer
  import rp_pkg::*;
#(
  parameter int NUM_NT  = 8,
  parameter int MAX_RHS = 4,
  parameter int NUM_T   = 16,
  parameter int MAX_REC = 32,
  parameter int WORD_W  = 8,
  parameter int DEPTH   = 64,
  localparam int SYM_W  = $clog2(NUM_NT),
  localparam int CNT_W  = $clog2(MAX_RHS + 1),
  localparam int ID_W   = $clog2(imax(MAX_REC, NUM_T)),
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SYM_W-1:0]  sym_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              child_valid_i,
  input  logic              child_tag_i,
  input  logic [ID_W-1:0]   child_id_i,
  input  logic              flush_i,
  output logic              ready_o,
  output logic              fault_o,
  output logic [ID_W-1:0]   rec_idx_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o
);
  // a field must fit in one word so each push emits at most one word
  localparam int FLD_W = imax(SYM_W + CNT_W, ID_W + 1);
  localparam int LEN_W = $clog2(FLD_W + 1);

  logic             push, flush_g, ovf;
  logic [FLD_W-1:0] fval;
  logic [LEN_W-1:0] flen;

  rp_ctrl #(
    .SYM_W(SYM_W), .CNT_W(CNT_W), .ID_W(ID_W), .FLD_W(FLD_W), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk_i, .rst_ni, .start_i, .sym_i, .count_i,
    .child_valid_i, .child_tag_i, .child_id_i, .flush_i,
    .ovf_i(ovf), .push_o(push), .fval_o(fval), .flen_o(flen),
    .flush_o(flush_g), .ready_o, .fault_o, .rec_idx_o
  );

  rp_accum #(
    .WORD_W(WORD_W), .FLD_W(FLD_W), .LEN_W(LEN_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)
  ) u_accum (
    .clk_i, .rst_ni, .push_i(push), .fval_i(fval), .flen_i(flen),
    .flush_i(flush_g), .ovf_o(ovf), .we_o(mem_we_o), .addr_o(mem_addr_o),
    .wdata_o(mem_wdata_o)
  );
endmodule

// File: rtl/parse_record_packer_chk.sv
module parse_record_packer_chk #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_o,
  input logic              fault_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o
);
  logic [ADDR_W:0] nxt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       nxt_q <= '0;
    else if (mem_we_o) nxt_q <= nxt_q + 1'b1;
  end

  a_r9_fault_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> fault_o);
  a_r9_fault_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !ready_o);
  a_r9_fault_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> !mem_we_o);
  a_r5_addr_seq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_addr_o == nxt_q[ADDR_W-1:0]));
  a_r9_addr_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (nxt_q < (ADDR_W+1)'(DEPTH)));
endmodule

bind parse_record_packer parse_record_packer_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ready_o(ready_o), .fault_o(fault_o),
  .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o)
);

// File: tb/sim_parse_record_packer.sv
module sim_parse_record_packer;
  // defaults give SYM_W=3, CNT_W=3, ID_W=5; depth reduced to 16 words
  localparam int DEPTH = 16;

  typedef struct packed {
    logic [2:0] sym;
    logic [2:0] cnt;
    logic [5:0] k0, k1, k2, k3;  // {tag, id}
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{sym: 3'd2, cnt: 3'd1, k0: {1'b0, 5'd9},  k1: 6'd0,          k2: 6'd0,          k3: 6'd0},
    '{sym: 3'd1, cnt: 3'd2, k0: {1'b0, 5'd8},  k1: {1'b1, 5'd0},  k2: 6'd0,          k3: 6'd0},
    '{sym: 3'd3, cnt: 3'd1, k0: {1'b0, 5'd11}, k1: 6'd0,          k2: 6'd0,          k3: 6'd0},
    '{sym: 3'd0, cnt: 3'd3, k0: {1'b1, 5'd1},  k1: {1'b0, 5'd10}, k2: {1'b1, 5'd2},  k3: 6'd0},
    '{sym: 3'd7, cnt: 3'd0, k0: 6'd0,          k1: 6'd0,          k2: 6'd0,          k3: 6'd0},
    '{sym: 3'd4, cnt: 3'd4, k0: {1'b0, 5'd31}, k1: {1'b1, 5'd4},  k2: {1'b0, 5'd0},  k3: {1'b1, 5'd3}}
  };

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       start_i = 1'b0, child_valid_i = 1'b0, child_tag_i = 1'b0, flush_i = 1'b0;
  logic [2:0] sym_i = '0, count_i = '0;
  logic [4:0] child_id_i = '0;
  logic       ready_o, fault_o, mem_we_o;
  logic [4:0] rec_idx_o;
  logic [3:0] mem_addr_o;
  logic [7:0] mem_wdata_o;

  int n_chk = 0, n_fail = 0, wr_cnt = 0, pos = 0;
  logic [7:0]   cap [DEPTH];
  logic [255:0] exp_s;

  always #5 clk_i = ~clk_i;

  parse_record_packer #(.DEPTH(DEPTH)) u0 (.*);

  always @(negedge clk_i) begin
    if (mem_we_o) begin
      cap[mem_addr_o] = mem_wdata_o;
      wr_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [5:0] val, input int len);
    for (int b = 0; b < len; b++) exp_s[pos+b] = val[b];
    pos += len;
  endtask

  function automatic logic [5:0] kid(input vec_t v, input int i);
    case (i)
      0: return v.k0;
      1: return v.k1;
      2: return v.k2;
      default: return v.k3;
    endcase
  endfunction

  function automatic int getb(input int p, input int len);
    int r = 0;
    for (int b = 0; b < len; b++) r |= int'(cap[(p+b)/8][(p+b)%8]) << b;
    return r;
  endfunction

  task automatic do_rec(input vec_t v, input int idx, input bit gap);
    chk(ready_o == 1'b1 && rec_idx_o == 5'(idx), "R4 index at ready", rec_idx_o, idx);
    start_i = 1'b1; sym_i = v.sym; count_i = v.cnt;
    put({v.cnt, v.sym}, 6);
    @(negedge clk_i);
    start_i = 1'b0;
    chk(ready_o == (v.cnt == 0), v.cnt == 0 ? "R7 zero-child ready" : "R6 busy",
        ready_o, v.cnt == 0);
    for (int i = 0; i < int'(v.cnt); i++) begin
      if (gap && i == 1) begin
        child_valid_i = 1'b0; start_i = 1'b1; sym_i = 3'd5; count_i = 3'd0;
        @(negedge clk_i);
        start_i = 1'b0;
      end
      child_valid_i = 1'b1;
      {child_tag_i, child_id_i} = kid(v, i);
      put({kid(v, i), kid(v, i)[5]} >> 0 == 0 ? 6'd0 : {kid(v, i)[4:0], kid(v, i)[5]}, 6);
      @(negedge clk_i);
      child_valid_i = 1'b0;
    end
    chk(ready_o == 1'b1, "R6 ready after children", ready_o, 1);
  endtask

  task automatic pulse_flush;
    flush_i = 1'b1;
    @(negedge clk_i);
    flush_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    exp_s = '0;
    repeat (3) @(negedge clk_i);
    chk(ready_o && !fault_o && rec_idx_o == 0 && !mem_we_o, "R1 in reset", ready_o, 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(ready_o && !fault_o && rec_idx_o == 0 && wr_cnt == 0, "R1 after reset", wr_cnt, 0);

    for (int i = 0; i < 6; i++) do_rec(VECS[i], i, i == 1);
    @(negedge clk_i);
    chk(wr_cnt == pos / 8, "R5 full words before flush", wr_cnt, pos / 8);

    pulse_flush();
    chk(wr_cnt == 13, "R8 partial word written", wr_cnt, 13);
    chk(cap[12] == exp_s[96 +: 8] && cap[12][7:6] == 2'b00, "R8 zero padding",
        cap[12], exp_s[96 +: 8]);
    pulse_flush();
    chk(wr_cnt == 13, "R8 empty flush writes nothing", wr_cnt, 13);

    pos = 104;
    do_rec('{sym: 3'd5, cnt: 3'd0, k0: 6'd0, k1: 6'd0, k2: 6'd0, k3: 6'd0}, 6, 1'b0);
    pulse_flush();
    chk(wr_cnt == 14 && cap[13] == {2'b00, 3'd0, 3'd5}, "R8 next record at bit 0 of next word",
        cap[13], {2'b00, 3'd0, 3'd5});

    for (int w = 0; w < 14; w++)
      chk(cap[w] == exp_s[8*w +: 8], "R5 packed word", cap[w], exp_s[8*w +: 8]);

    begin
      int p = 0;
      for (int r = 0; r < 6; r++) begin
        bit ok = 1'b1;
        if (getb(p, 3) != int'(VECS[r].sym)) ok = 1'b0;
        if (getb(p + 3, 3) != int'(VECS[r].cnt)) ok = 1'b0;
        chk(ok, "R2 header fields", getb(p, 6), {VECS[r].cnt, VECS[r].sym});
        p += 6;
        for (int i = 0; i < int'(VECS[r].cnt); i++) begin
          chk(getb(p, 1) == int'(kid(VECS[r], i)[5]) && getb(p + 1, 5) == int'(kid(VECS[r], i)[4:0]),
              "R3 slot tag and id", getb(p, 6), {kid(VECS[r], i)[4:0], kid(VECS[r], i)[5]});
          p += 6;
        end
      end
    end

    // overflow: 30-bit records into 128 bits; word 16 is needed mid record 4
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1; wr_cnt = 0;
    @(negedge clk_i);
    for (int r = 0; r < 6; r++) begin
      start_i = 1'b1; sym_i = 3'd6; count_i = 3'd4;
      @(negedge clk_i);
      start_i = 1'b0;
      for (int i = 0; i < 4; i++) begin
        child_valid_i = 1'b1; child_tag_i = 1'b0; child_id_i = 5'd31;
        @(negedge clk_i);
        child_valid_i = 1'b0;
      end
    end
    @(negedge clk_i);
    chk(fault_o == 1'b1 && ready_o == 1'b0, "R9 fault raised", fault_o, 1);
    chk(wr_cnt == DEPTH, "R9 no write past last address", wr_cnt, DEPTH);
    start_i = 1'b1; count_i = 3'd0; flush_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0; flush_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk(fault_o == 1'b1 && wr_cnt == DEPTH && rec_idx_o == 0, "R9 sticky and inputs ignored",
        wr_cnt, DEPTH);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(fault_o == 1'b0 && ready_o == 1'b1, "R1 reset clears fault", fault_o, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule